// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software by counting a 7-bit value down from a software-loaded start point. The count advances on a slow tick made by dividing the peripheral clock by a power of two, with a 2-bit timebase field that multiplies the base division by 1, 2, 4 or 8. Software must reload the counter before bit 6 of the counter drops. It must also reload only once the counter has fallen to or below a programmed window value. A reload that comes too early, a timeout, or a load with bit 6 clear each raise a one-cycle system reset request.

Shortly before expiry, when the counter decrements into 0x40, a sticky early-warning flag sets. If its enable bit is set, the flag drives an interrupt line, which gives a handler one last tick period to reload. Once the watchdog is started, software cannot stop it; only a block reset clears the run state. A debug freeze, which needs both the halt input and the stop-permission input, stops the prescaler and the counter.

Three registers sit on a simple synchronous bus with a 2-bit address and 16-bit data. Reads return data in the cycle after the read strobe.

Top module: `winwdog_top`

## Requirements
- R1: After reset the watchdog is stopped, the counter holds 0x7F, the window holds 0x7F, the timebase is 0, the warning enable is 0, the flag is 0, and both outputs are low. The reset release passes through two synchronising flops.
- R2: Register map. Address 0 (control): bit 7 run, bits 6:0 counter. Address 1 (configuration): bits 6:0 window, bits 8:7 timebase, bit 9 warning-interrupt enable. Address 2 (status): bit 0 warning flag. Address 3 reads as zero, and unused bits read as zero. Read data appears in the cycle after `rd_en`.
- R3: Writing 1 to control bit 7 starts the watchdog. Writing 0 there later has no effect, and only reset stops it.
- R4: The counter decrements by one per tick while running, with one tick every 2^(PRE_LOG2+tb) clocks. While stopped it holds its value. A control write always loads bits 6:0.
- R5: After a start with counter 0x40+r, counted from a prescaler at zero, `rst_req` goes high for one cycle exactly (r+1) ticks later, on the decrement from 0x40 to 0x3F.
- R6: A control write while running and with the counter above the window raises `rst_req` in the next cycle. With the counter equal to or below the window, no request is raised.
- R7: A control write that leaves the watchdog running with written bit 6 equal to 0 raises `rst_req` in the next cycle.
- R8: The flag sets on the decrement into 0x40. A status write with bit 0 = 0 clears it, and a status write with bit 0 = 1 leaves it unchanged.
- R9: `ew_irq` is high exactly while the flag and the warning enable are both set.
- R10: With `dbg_halt` and `dbg_stop_en` both high, the prescaler and counter freeze, so expiry is delayed by the frozen cycles. Either input alone has no effect.
- R11: A configuration write that changes the timebase restarts the prescaler from zero. The write itself takes effect at the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| dbg_halt | input | 1 | Core halted in debug |
| dbg_stop_en | input | 1 | Permission to freeze while halted |
| rst_req | output | 1 | One-cycle system reset request |
| ew_irq | output | 1 | Early-warning interrupt |

## Verification
A wrong prescaler phase or limit moves the expiry cycle by whole ticks, so the reset request lands on the wrong cycle. The bench detects this within one timeout, because it sweeps the timebase and the reload value and compares the exact arrival cycle with the arithmetic product. A corrupted counter, window or flag appears either as a reset request on a legal reload (or a missing one on an early reload) in the very next cycle, or as an interrupt that rises one tick too early or too late. A run bit that clears would let an expiry pass silently, and the bench would see no reset request in the window where one is due.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int CNT_W  = 7;
  localparam int TB_W   = 2;
  localparam int DATA_W = 16;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CFG  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  localparam logic [CNT_W-1:0] CNT_EXPIRE = 7'h40;
  localparam logic [CNT_W-1:0] CNT_WARN   = 7'h41;
  localparam logic [CNT_W-1:0] CNT_RESET  = 7'h7F;

  typedef struct packed {
    logic             ewie;
    logic [TB_W-1:0]  tb;
    logic [CNT_W-1:0] win;
  } cfg_t;
endpackage

// File: rtl/wwd_presc.sv
module wwd_presc #(
  parameter int PRE_LOG2 = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] tb,
  output logic       tick
);
  localparam int PW = PRE_LOG2 + 3;

  logic [PW-1:0] cnt_q, cnt_d, lim;
  logic          cnt_en;

  always_comb begin
    lim    = {PW{1'b1}} >> (2'd3 - tb);
    tick   = run && !restart && (cnt_q == lim);
    cnt_en = restart || run;
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wwd_core.sv
module wwd_core
  import wwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctrl_wr,
  input  logic             w_run,
  input  logic [CNT_W-1:0] w_cnt,
  input  logic [CNT_W-1:0] win,
  input  logic             stat_wr,
  input  logic             w_flag,
  output logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic             flag,
  output logic             rst_req
);
  logic             en_q, en_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             req_q, req_d;
  logic             dec, underflow, early, low_load, warn_hit;

  always_comb begin
    dec       = en_q && tick && !ctrl_wr;
    en_d      = en_q || (ctrl_wr && w_run);
    underflow = dec && (cnt_q == CNT_EXPIRE);
    warn_hit  = dec && (cnt_q == CNT_WARN);
    early     = ctrl_wr && en_q && (cnt_q > win);
    low_load  = ctrl_wr && en_d && !w_cnt[CNT_W-1];
    req_d     = underflow || early || low_load;

    if (ctrl_wr)  cnt_d = w_cnt;
    else if (dec) cnt_d = cnt_q - CNT_W'(1);
    else          cnt_d = cnt_q;

    if (warn_hit)                flag_d = 1'b1;
    else if (stat_wr && !w_flag) flag_d = 1'b0;
    else                         flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cnt_q  <= CNT_RESET;
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
      req_q  <= req_d;
    end
  end

  assign en      = en_q;
  assign cnt     = cnt_q;
  assign flag    = flag_q;
  assign rst_req = req_q;
endmodule

// File: rtl/wwd_regs.sv
module wwd_regs
  import wwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              en,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output cfg_t              cfg,
  output logic              ctrl_wr,
  output logic              stat_wr,
  output logic              tb_chg,
  output logic [DATA_W-1:0] rdata
);
  cfg_t              cfg_q, cfg_d;
  logic              cfg_wr;
  logic [DATA_W-1:0] rd_q, rd_d;

  always_comb begin
    ctrl_wr = wr_en && (addr == A_CTRL);
    cfg_wr  = wr_en && (addr == A_CFG);
    stat_wr = wr_en && (addr == A_STAT);
    cfg_d   = cfg_t'(wdata[CNT_W+TB_W:0]);
    tb_chg  = cfg_wr && (cfg_d.tb != cfg_q.tb);
    rd_d    = '0;
    case (addr)
      A_CTRL:  rd_d = {8'h00, en, cnt};
      A_CFG:   rd_d = DATA_W'(cfg_q);
      A_STAT:  rd_d = {15'h0000, flag};
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{ewie: 1'b0, tb: '0, win: CNT_RESET};
      rd_q  <= '0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_d;
      if (rd_en)  rd_q  <= rd_d;
    end
  end

  assign cfg   = cfg_q;
  assign rdata = rd_q;
endmodule

// File: rtl/winwdog_top.sv
module winwdog_top
  import wwd_pkg::*;
#(
  parameter int PRE_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        dbg_halt,
  input  logic        dbg_stop_en,
  output logic        rst_req,
  output logic        ew_irq
);
  logic [1:0]       rs_q;
  logic             rst_i_n;
  cfg_t             cfg;
  logic             ctrl_wr, stat_wr, tb_chg, tick, frz, run;
  logic             en, flag;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign frz = dbg_halt && dbg_stop_en;
  assign run = en && !frz;

  wwd_regs u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .en(en), .cnt(cnt), .flag(flag), .cfg(cfg),
    .ctrl_wr(ctrl_wr), .stat_wr(stat_wr), .tb_chg(tb_chg), .rdata(rdata)
  );

  wwd_presc #(.PRE_LOG2(PRE_LOG2)) u_presc (
    .clk(clk), .rst_n(rst_i_n), .run(run), .restart(tb_chg),
    .tb(cfg.tb), .tick(tick)
  );

  wwd_core u_core (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .ctrl_wr(ctrl_wr),
    .w_run(wdata[7]), .w_cnt(wdata[6:0]), .win(cfg.win),
    .stat_wr(stat_wr), .w_flag(wdata[0]), .en(en), .cnt(cnt),
    .flag(flag), .rst_req(rst_req)
  );

  assign ew_irq = flag && cfg.ewie;
endmodule

// File: rtl/winwdog_chk.sv
module winwdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic       en,
  input logic [6:0] cnt,
  input logic       flag,
  input logic       tick,
  input logic       frz,
  input logic       rst_req
);
  logic cw;
  assign cw = wr_en && (addr == 2'd0);

  p_run_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cw) |=> $stable(cnt));

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cw) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 7'd1));

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !cw) |=> $stable(cnt));

  p_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !cw && cnt == 7'h40) |=> rst_req);

  p_warn_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (cnt == 7'h40));
endmodule

bind winwdog_top winwdog_chk u_chk (
  .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .addr(addr), .en(en),
  .cnt(cnt), .flag(flag), .tick(tick), .frz(frz), .rst_req(rst_req)
);

// File: tb/sim_winwdog_top.sv
module sim_winwdog_top;
  localparam int TCLK = 10;
  localparam int PL   = 2;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, rd_en, dbg_halt, dbg_stop_en;
  logic [1:0]  addr;
  logic [15:0] wdata, rdata;
  logic        rst_req, ew_irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  winwdog_top #(.PRE_LOG2(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .dbg_halt(dbg_halt),
    .dbg_stop_en(dbg_stop_en), .rst_req(rst_req), .ew_irq(ew_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    dbg_halt = 0; dbg_stop_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk) rd_en = 1'b0;
    d = rdata;
  endtask

  // Cycles from the start edge to the first cycle with rst_req high.
  task automatic measure(input int kfrz, input bit both, input int cfg_at,
                         input logic [15:0] cfg_v, input int lim, output int n);
    n = 0;
    if (kfrz > 0) begin dbg_halt = 1'b1; dbg_stop_en = both; end
    while (n < lim) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == kfrz) begin dbg_halt = 1'b0; dbg_stop_en = 1'b0; end
      if (n == cfg_at) begin wr_en = 1'b1; addr = 2'd1; wdata = cfg_v; end
      else if (n == cfg_at + 1) wr_en = 1'b0;
      if (rst_req) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int n, exp;
    int rs [8] = '{0, 1, 2, 5, 13, 31, 62, 63};

    // R1, R2 reset state and register map
    do_reset();
    chk(!rst_req && !ew_irq, "R1 outputs", {rst_req, ew_irq}, 0);
    rd(2'd0, d); chk(d == 16'h007F, "R1 ctrl", d, 16'h007F);
    rd(2'd1, d); chk(d == 16'h007F, "R1 cfg", d, 16'h007F);
    rd(2'd2, d); chk(d == 16'h0000, "R1 stat", d, 0);
    rd(2'd3, d); chk(d == 16'h0000, "R2 addr3", d, 0);
    wr(2'd1, 16'h03AB); rd(2'd1, d);
    chk(d == 16'h03AB, "R2 cfg fields", d, 16'h03AB);

    // R4 stopped counter loads and holds; R7 not applied while stopped
    do_reset();
    wr(2'd0, 16'h0055);
    chk(!rst_req, "R7 stopped low load", rst_req, 0);
    repeat (50) @(negedge clk);
    rd(2'd0, d); chk(d == 16'h0055, "R4 hold stopped", d, 16'h0055);

    // R4, R5 sweep: all r at tb 0, selected r at every tb
    for (int r = 0; r < 64; r++) begin
      do_reset();
      wr(2'd0, 16'(8'hC0 | r));
      exp = 4 * (r + 1);
      measure(0, 0, -9, 0, exp + 5, n);
      chk(n == exp, "R5 timeout tb0", n, exp);
    end
    for (int t = 1; t < 4; t++) begin
      foreach (rs[i]) begin
        do_reset();
        wr(2'd1, 16'(16'h007F | (t << 7)));
        wr(2'd0, 16'(8'hC0 | rs[i]));
        exp = (4 << t) * (rs[i] + 1);
        measure(0, 0, -9, 0, exp + 5, n);
        chk(n == exp, "R4 tick period per timebase", n, exp);
      end
    end
    // R5 pulse is one cycle wide
    @(negedge clk); chk(!rst_req, "R5 single pulse", rst_req, 0);

    // R3 run bit sticky
    do_reset();
    wr(2'd0, 16'h00FF);
    wr(2'd0, 16'h007F);
    rd(2'd0, d); chk(d[7] == 1'b1, "R3 run sticky", d[7], 1);

    // R6 window boundaries
    do_reset();
    wr(2'd0, 16'h00FF);
    wr(2'd0, 16'h00FF);
    chk(!rst_req, "R6 cnt equal window", rst_req, 0);
    do_reset();
    wr(2'd1, 16'h007E);
    wr(2'd0, 16'h00FF);
    wr(2'd0, 16'h00FF);
    chk(rst_req, "R6 cnt above window", rst_req, 1);
    do_reset();
    wr(2'd1, 16'h0050);
    wr(2'd0, 16'h00FF);
    repeat (200) @(negedge clk);
    wr(2'd0, 16'h00FF);
    chk(!rst_req, "R6 refresh inside window", rst_req, 0);

    // R7 low load while running
    do_reset();
    wr(2'd0, 16'h00FF);
    wr(2'd0, 16'h00BF);
    chk(rst_req, "R7 bit6 clear load", rst_req, 1);

    // R8, R9 warning with interrupt enabled
    do_reset();
    wr(2'd1, 16'h027F);
    wr(2'd0, 16'h00C3);
    for (int k = 1; k <= 16; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 11) chk(!ew_irq, "R8 no early warn", ew_irq, 0);
      if (k == 12) chk(ew_irq, "R9 warn irq", ew_irq, 1);
      if (k == 16) chk(rst_req, "R5 expiry after warn", rst_req, 1);
    end
    wr(2'd2, 16'h0000);
    chk(!ew_irq, "R8 flag clear", ew_irq, 0);

    // R8, R9 warning with interrupt disabled
    do_reset();
    wr(2'd0, 16'h00C1);
    repeat (6) @(negedge clk);
    chk(!ew_irq, "R9 masked irq", ew_irq, 0);
    rd(2'd2, d); chk(d == 16'h0001, "R8 flag set", d, 1);
    wr(2'd2, 16'h0001);
    rd(2'd2, d); chk(d == 16'h0001, "R8 write one keeps", d, 1);
    wr(2'd2, 16'h0000);
    rd(2'd2, d); chk(d == 16'h0000, "R8 write zero clears", d, 0);

    // R10 debug freeze
    do_reset();
    wr(2'd0, 16'h00C2);
    measure(7, 1, -9, 0, 40, n);
    chk(n == 19, "R10 freeze both", n, 19);
    do_reset();
    wr(2'd0, 16'h00C2);
    measure(7, 0, -9, 0, 40, n);
    chk(n == 12, "R10 halt alone", n, 12);

    // R11 timebase change restarts prescaler
    do_reset();
    wr(2'd0, 16'h00C0);
    measure(0, 0, 2, 16'h00FF, 40, n);
    chk(n == 11, "R11 prescaler restart", n, 11);
    do_reset();
    wr(2'd0, 16'h00C0);
    measure(0, 0, 2, 16'h007F, 40, n);
    chk(n == 4, "R11 same timebase no restart", n, 4);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule